// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a storage register, eight bits by default, with four synchronous operating modes picked by a two-bit select: keep the stored value, shift toward the high stage, shift toward the low stage, or capture a parallel word. Parallel data enters and leaves on one logical set of bus lines. In synthesizable form these lines are a bus-in, bus-out and drive-enable triple, which the pad ring or a board-level tri-state buffer merges into one shared set of wires.

Two active-low output enables control the bus drivers. The drivers also switch off by themselves whenever load mode is selected, so an external source can place the load word on the shared lines. The lowest and highest stages each have a dedicated serial tap that is never disabled. Several registers can therefore be chained into longer words. Each shift direction has its own serial input. An asynchronous active-low reset clears the register at once and overrides the clock and the select.

Top module: `shreg_bidir`

## Requirements
- R1: While `rst_n` is low, every stage clears to zero straight away, with no clock edge needed, whatever the select inputs hold. `bus_out`, `tap_lo` and `tap_hi` all read 0.
- R2: With `sel` = 2'b00 (hold), a rising clock edge leaves the stored word unchanged.
- R3: With `sel` = 2'b01 (shift right), a rising edge moves stage n into stage n+1 and loads `ser_r_in` into stage 0. Stage 0 is bit 0 of `bus_out`.
- R4: With `sel` = 2'b10 (shift left), a rising edge moves stage n into stage n-1 and loads `ser_l_in` into the top stage (bit WIDTH-1).
- R5: With `sel` = 2'b11 (load), a rising edge copies `bus_in` into the register.
- R6: `bus_out` always carries the current register contents, bit n for stage n.
- R7: `bus_oe` is 1 only when both bits of `oe_n` are 0 and `sel` is not 2'b11. Otherwise it is 0, and the shared lines are released.
- R8: `tap_lo` always equals stage 0 and `tap_hi` always equals the top stage, whatever `oe_n` and `sel` hold.
- R9: Hold, both shifts, load and reset work the same way while `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Mode select: 00 hold, 01 shift right, 10 shift left, 11 load |
| oe_n | input | 2 | Output enables, both active low |
| ser_r_in | input | 1 | Serial input to stage 0 for right shifts |
| ser_l_in | input | 1 | Serial input to the top stage for left shifts |
| bus_in | input | WIDTH | Value seen on the shared lines, used as load data |
| bus_out | output | WIDTH | Register contents driven toward the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| tap_lo | output | 1 | Stage 0 serial tap, always driven |
| tap_hi | output | 1 | Top stage serial tap, always driven |

## Verification
A wrong stage value appears on `bus_out` right after the rising edge that produced it, and on a tap if it sits at an end stage. Because `bus_out` does not depend on the enables, a fault that happens while the drivers are off is still seen in the same cycle. A bad shift link shows up as a misplaced bit within one or two shifts. A wrong enable term is visible on `bus_oe` with no clock edge at all.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/shreg_next.sv
module shreg_next
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  mode_e             mode,
  input  logic [WIDTH-1:0]  q,
  input  logic [WIDTH-1:0]  par_in,
  input  logic              ser_r,
  input  logic              ser_l,
  output logic [WIDTH-1:0]  d
);
  localparam int unsigned TOP = WIDTH - 1;

  // Per-stage source selection; end stages take the serial inputs.
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_low;
    logic from_high;

    if (i == 0) begin : g_lo_end
      assign from_low = ser_r;
    end else begin : g_lo_mid
      assign from_low = q[i-1];
    end

    if (i == TOP) begin : g_hi_end
      assign from_high = ser_l;
    end else begin : g_hi_mid
      assign from_high = q[i+1];
    end

    always_comb begin
      unique case (mode)
        MODE_HOLD: d[i] = q[i];
        MODE_SHR:  d[i] = from_low;
        MODE_SHL:  d[i] = from_high;
        MODE_LOAD: d[i] = par_in[i];
        default:   d[i] = q[i];
      endcase
    end
  end
endmodule

// File: rtl/shreg_stages.sv
module shreg_stages #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_ff
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/shreg_drive.sv
module shreg_drive
  import shreg_pkg::*;
#(
  parameter int unsigned N_OE = 2
) (
  input  mode_e           mode,
  input  logic [N_OE-1:0] oe_n,
  output logic            drv_en
);
  logic all_enabled;
  logic load_sel;

  assign all_enabled = ~|oe_n;
  assign load_sel    = (mode == MODE_LOAD);
  assign drv_en      = all_enabled & ~load_sel;
endmodule

// File: rtl/shreg_bidir.sv
module shreg_bidir
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned N_OE  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic [N_OE-1:0]  oe_n,
  input  logic             ser_r_in,
  input  logic             ser_l_in,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             tap_lo,
  output logic             tap_hi
);
  localparam int unsigned TOP = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] d;

  assign mode = mode_e'(sel);

  shreg_next #(.WIDTH(WIDTH)) u_next (
    .mode   (mode),
    .q      (q),
    .par_in (bus_in),
    .ser_r  (ser_r_in),
    .ser_l  (ser_l_in),
    .d      (d)
  );

  shreg_stages #(.WIDTH(WIDTH)) u_stages (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (d),
    .q     (q)
  );

  shreg_drive #(.N_OE(N_OE)) u_drive (
    .mode   (mode),
    .oe_n   (oe_n),
    .drv_en (bus_oe)
  );

  assign bus_out = q;
  assign tap_lo  = q[0];
  assign tap_hi  = q[TOP];
endmodule

// File: rtl/shreg_bidir_chk.sv
module shreg_bidir_chk #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned N_OE  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sel,
  input logic [N_OE-1:0]  oe_n,
  input logic             ser_r_in,
  input logic             ser_l_in,
  input logic [WIDTH-1:0] bus_in,
  input logic [WIDTH-1:0] bus_out,
  input logic             bus_oe,
  input logic             tap_lo,
  input logic             tap_hi
);
  // R2: hold keeps the word
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |=> $stable(bus_out));

  // R3: right shift
  assert_shift_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b01) |=> (bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_r_in)}));

  // R4: left shift
  assert_shift_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10) |=> (bus_out == {$past(ser_l_in), $past(bus_out[WIDTH-1:1])}));

  // R5: parallel load
  assert_load_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |=> (bus_out == $past(bus_in)));

  // R7: load mode or any raised enable releases the bus
  assert_load_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> !bus_oe);
  assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n != '0) |-> !bus_oe);

  // R8: taps follow end stages
  assert_taps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_lo == bus_out[0]) && (tap_hi == bus_out[WIDTH-1]));
endmodule

bind shreg_bidir shreg_bidir_chk #(.WIDTH(WIDTH), .N_OE(N_OE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .oe_n(oe_n), .ser_r_in(ser_r_in),
  .ser_l_in(ser_l_in), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
  .tap_lo(tap_lo), .tap_hi(tap_hi)
);

// File: tb/sim_shreg_bidir.sv
module sim_shreg_bidir;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic [1:0]   oe_n = 2'b00;
  logic         ser_r_in = 1'b0;
  logic         ser_l_in = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out;
  logic         bus_oe;
  logic         tap_lo;
  logic         tap_hi;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] word;
    logic         oe;
    string        tag;
  } exp_t;
  exp_t sb[$];

  logic [W-1:0] model = '0;

  always #10 clk = ~clk;

  shreg_bidir u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .oe_n(oe_n), .ser_r_in(ser_r_in),
    .ser_l_in(ser_l_in), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .tap_lo(tap_lo), .tap_hi(tap_hi)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare queued expectations away from the active edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " word"}, bus_out, e.word);
      check("R8 tap_lo", {7'd0, tap_lo}, {7'd0, e.word[0]});
      check("R8 tap_hi", {7'd0, tap_hi}, {7'd0, e.word[W-1]});
      check("R7 bus_oe", {7'd0, bus_oe}, {7'd0, e.oe});
    end
  end

  // Driver: apply one cycle, update model, push expectation after the edge.
  task automatic step(logic [1:0] s, logic [1:0] oe, logic sr, logic sl,
                      logic [W-1:0] bi, string tag);
    exp_t e;
    sel = s; oe_n = oe; ser_r_in = sr; ser_l_in = sl; bus_in = bi;
    case (s)
      2'b00: model = model;
      2'b01: model = {model[W-2:0], sr};
      2'b10: model = {sl, model[W-1:1]};
      default: model = bi;
    endcase
    @(posedge clk);
    #1;
    e.word = model;
    e.oe   = (oe == 2'b00) && (s != 2'b11);
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    sel = 2'b11;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset word", bus_out, '0);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R5 load with drivers off by load mode, R7 auto release
    step(2'b11, 2'b00, 1'b0, 1'b0, 8'hA5, "R5");
    // R2 hold
    step(2'b00, 2'b00, 1'b1, 1'b1, 8'h00, "R2");
    step(2'b00, 2'b00, 1'b0, 1'b1, 8'hFF, "R2");
    // R3 right shifts
    step(2'b01, 2'b00, 1'b1, 1'b0, 8'h00, "R3");
    step(2'b01, 2'b00, 1'b0, 1'b1, 8'h00, "R3");
    step(2'b01, 2'b00, 1'b1, 1'b1, 8'h00, "R3");
    // R4 left shifts
    step(2'b10, 2'b00, 1'b0, 1'b1, 8'h00, "R4");
    step(2'b10, 2'b00, 1'b1, 1'b0, 8'h00, "R4");
    // R9 operations with drivers disabled by enables
    step(2'b01, 2'b01, 1'b1, 1'b0, 8'h00, "R9");
    step(2'b10, 2'b10, 1'b0, 1'b1, 8'h00, "R9");
    step(2'b11, 2'b11, 1'b0, 1'b0, 8'h3C, "R9");
    step(2'b00, 2'b10, 1'b1, 1'b1, 8'hC3, "R9");
    step(2'b00, 2'b00, 1'b0, 1'b0, 8'h00, "R6");
    // R3/R4 full rotation through the word
    for (int i = 0; i < W; i++) step(2'b01, 2'b00, i[0], 1'b0, 8'h00, "R3");
    for (int i = 0; i < W; i++) step(2'b10, 2'b00, 1'b0, ~i[0], 8'h00, "R4");
    step(2'b11, 2'b00, 1'b0, 1'b0, 8'hFF, "R5");

    // R1 asynchronous reset mid-cycle, no edge, with drivers off
    oe_n = 2'b11;
    #3;
    rst_n = 1'b0;
    #2;
    check("R1 async word", bus_out, '0);
    check("R1 async taps", {6'd0, tap_hi, tap_lo}, 8'h00);
    model = '0;
    @(negedge clk); #1;
    sel = 2'b01; ser_r_in = 1'b1;
    @(negedge clk); #1;
    check("R1 select ignored in reset", bus_out, '0);
    rst_n = 1'b1;
    step(2'b01, 2'b00, 1'b1, 1'b0, 8'h00, "R3");

    @(negedge clk); #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule